// File: doc/BRIEF.md
# Dual Selectable Baud Clock Generator

This block derives two independent 16x-oversampling clock enables, one for a receiver and one for a transmitter, from a single reference clock. Each channel holds a 4-bit rate code that picks one of sixteen standard baud rates from 50 to 19200. The code indexes a fixed integer divisor table. Each channel produces a single-cycle `*_tick` enable and a `*_wave` square wave. The `*_tick` enable suits a serial engine that shares the reference clock domain.

Each rate code is captured from its input bus on every clock edge while that channel's load input is high. Holding the load high makes the channel follow its bus directly. Pulsing the load latches a new rate. A new code never cuts the period in progress short: the counter finishes the current period and only then reloads with the new divisor.

The `TABLE_SET` parameter picks the divisor table at elaboration. Set 0 is matched to a 5.0688 MHz reference and set 1 to a 4.9152 MHz reference.

Top module: `dual_baud_gen`

## Requirements
- R1: The spacing between consecutive ticks of a channel equals the divisor of its active code, so the tick rate is the reference frequency over the divisor, which is 16 times the baud rate. With table set 0, code 0101 (300 baud) gives 1056 cycles, which is 4800 ticks per second.
- R2: The receive code register takes `rx_rate` on every clock edge where `rx_load` is high. While `rx_load` is low, changes on `rx_rate` have no effect on the receive output.
- R3: The transmit code register takes `tx_rate` on every clock edge where `tx_load` is high. While `tx_load` is low, changes on `tx_rate` have no effect. With `tx_load` held high, the channel follows `tx_rate`.
- R4: With `TABLE_SET`=0, codes 0 to 15 give divisors 6336, 4224, 2880, 2355, 2112, 1056, 528, 264, 176, 158, 132, 88, 66, 44, 33, 16. These are the nearest integers (ties rounding down) to 5068800 / (16 x baud) for the bauds 50, 75, 110, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600, 19200.
- R5: With `TABLE_SET`=1, codes 0 to 15 give divisors 6144, 4096, 2793, 2284, 2048, 1024, 512, 256, 171, 154, 128, 85, 64, 43, 32, 16. These are the same rounding of 4915200 / (16 x baud).
- R6: A code change takes effect only at the channel's next tick. The period in progress completes at its old length, and the next period has the new length.
- R7: Within each period of divisor D, `*_wave` is high for the first D - floor(D/2) cycles and low for the remaining floor(D/2) cycles. `*_tick` coincides with the last low cycle.
- R8: The two channels run independently. Different codes on receive and transmit each give their own period.
- R9: Synchronous active-high `rst` sets both codes to 0000 and restarts both counters. During and just after reset, `*_tick` is 0 and `*_wave` is 1. The first tick after release comes D0 - 1 cycles after the first non-reset edge, where D0 is the divisor for code 0000. Every later period is D0 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_rate | input | 4 | Receive rate code |
| rx_load | input | 1 | Receive code load enable (level) |
| tx_rate | input | 4 | Transmit rate code |
| tx_load | input | 1 | Transmit code load enable (level) |
| rx_tick | output | 1 | Receive 16x enable, one cycle per period |
| rx_wave | output | 1 | Receive 16x square wave |
| tx_tick | output | 1 | Transmit 16x enable, one cycle per period |
| tx_wave | output | 1 | Transmit 16x square wave |

## Verification
The bench goes after the odd divisors (2355, 2793, 171, 85, 43, 33), where an off-by-one in the reload, or a truncating instead of rounding table, would show up as a period one cycle too long or too short. It also targets the wave duty split on odd divisors, where a wrong half-point computation would leave one extra cycle high or low.

A code change is made in the middle of a period. A design that reloaded immediately would emit a short runt period instead of finishing the old one.

Loads with the strobe low, and the strobe tied high, separate a design that latched on edges, or ignored the level, from the intended level capture. A mid-run reset checks that a stale code or counter value does not survive.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int CODE_W = 4;
  localparam int DIV_W  = 13;

  // Divisor for a rate code. Set 0 matches a 5.0688 MHz reference,
  // set 1 a 4.9152 MHz reference; both give 16x the nominal baud.
  function automatic logic [DIV_W-1:0] divisor_for(input int unsigned set_sel,
                                                   input logic [CODE_W-1:0] code);
    logic [DIV_W-1:0] d;
    if (set_sel == 1) begin
      case (code)
        4'd0:  d = 13'd6144;
        4'd1:  d = 13'd4096;
        4'd2:  d = 13'd2793;
        4'd3:  d = 13'd2284;
        4'd4:  d = 13'd2048;
        4'd5:  d = 13'd1024;
        4'd6:  d = 13'd512;
        4'd7:  d = 13'd256;
        4'd8:  d = 13'd171;
        4'd9:  d = 13'd154;
        4'd10: d = 13'd128;
        4'd11: d = 13'd85;
        4'd12: d = 13'd64;
        4'd13: d = 13'd43;
        4'd14: d = 13'd32;
        default: d = 13'd16;
      endcase
    end else begin
      case (code)
        4'd0:  d = 13'd6336;
        4'd1:  d = 13'd4224;
        4'd2:  d = 13'd2880;
        4'd3:  d = 13'd2355;
        4'd4:  d = 13'd2112;
        4'd5:  d = 13'd1056;
        4'd6:  d = 13'd528;
        4'd7:  d = 13'd264;
        4'd8:  d = 13'd176;
        4'd9:  d = 13'd158;
        4'd10: d = 13'd132;
        4'd11: d = 13'd88;
        4'd12: d = 13'd66;
        4'd13: d = 13'd44;
        4'd14: d = 13'd33;
        default: d = 13'd16;
      endcase
    end
    return d;
  endfunction

  // Square wave level: high while the down-counter is in the upper part
  // of the period (div - div/2 cycles), low for the remaining div/2 cycles.
  function automatic logic wave_level(input logic [DIV_W-1:0] cnt,
                                      input logic [DIV_W-1:0] div);
    return cnt >= (div >> 1);
  endfunction

endpackage

// File: rtl/rate_select_reg.sv
module rate_select_reg
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (load) code_q <= code_in;
  end

  // R9: reset returns the code to 0000
  a_r9_reset_code: assert property (@(posedge clk) rst |=> (code_q == '0));

  // R2/R3: level capture while load is high
  a_r2_r3_capture: assert property (@(posedge clk) disable iff (rst)
    load |=> (code_q == $past(code_in)));

  // R2/R3: bus changes are ignored while load is low
  a_r2_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(code_q));

endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_pkg::*;
#(
  parameter int unsigned TABLE_SET = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              tick,
  output logic              wave
);

  localparam logic [DIV_W-1:0] ONE     = 1;
  localparam logic [DIV_W-1:0] DIV_RST = divisor_for(TABLE_SET, 4'd0);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] act_div;
  logic [DIV_W-1:0] next_div;
  logic             at_term;

  assign next_div = divisor_for(TABLE_SET, code);
  assign at_term  = (cnt == '0);

  // Reload only at terminal count, so a code change never shortens a period.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_div <= DIV_RST;
      cnt     <= DIV_RST - ONE;
    end else if (at_term) begin
      act_div <= next_div;
      cnt     <= next_div - ONE;
    end else begin
      cnt     <= cnt - ONE;
    end
  end

  assign tick = at_term;
  assign wave = wave_level(cnt, act_div);

  // Checker-side cycle counter since the last tick.
  logic [DIV_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst || at_term) gap <= ONE;
    else                gap <= gap + ONE;
  end

  // R1: tick spacing equals the divisor of the period just ended
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == act_div));

  // R6: active divisor changes only across a terminal count
  a_r6_no_midperiod_reload: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(act_div));

  // R7: tick falls in a low cycle, and the wave is high right after it
  a_r7_wave_low_at_tick: assert property (@(posedge clk) disable iff (rst)
    tick |-> !wave);
  a_r7_wave_high_after_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> wave);

  // R9: reset restarts the counter at the code-0000 divisor
  a_r9_reset_restart: assert property (@(posedge clk)
    rst |=> (!tick && wave && act_div == DIV_RST));

endmodule

// File: rtl/dual_baud_gen.sv
module dual_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned TABLE_SET = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rx_rate,
  input  logic       rx_load,
  input  logic [3:0] tx_rate,
  input  logic       tx_load,
  output logic       rx_tick,
  output logic       rx_wave,
  output logic       tx_tick,
  output logic       tx_wave
);

  localparam int N_CH = 2;  // index 0 = receive, 1 = transmit

  logic [N_CH-1:0][CODE_W-1:0] rate_in;
  logic [N_CH-1:0][CODE_W-1:0] rate_q;
  logic [N_CH-1:0]             load_in;
  logic [N_CH-1:0]             tick_o;
  logic [N_CH-1:0]             wave_o;

  assign rate_in = {tx_rate, rx_rate};
  assign load_in = {tx_load, rx_load};

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    rate_select_reg u_sel (
      .clk     (clk),
      .rst     (rst),
      .load    (load_in[g]),
      .code_in (rate_in[g]),
      .code_q  (rate_q[g])
    );

    baud_divider #(.TABLE_SET(TABLE_SET)) u_div (
      .clk  (clk),
      .rst  (rst),
      .code (rate_q[g]),
      .tick (tick_o[g]),
      .wave (wave_o[g])
    );
  end

  assign rx_tick = tick_o[0];
  assign rx_wave = wave_o[0];
  assign tx_tick = tick_o[1];
  assign tx_wave = wave_o[1];

endmodule

// File: tb/dual_baud_gen_test.sv
`timescale 1ns/1ps
module dual_baud_gen_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] rx_rate = '0, tx_rate = '0, a_rx_rate = '0;
  logic rx_load = 1'b0, tx_load = 1'b0, a_rx_load = 1'b0;
  logic rx_tick, rx_wave, tx_tick, tx_wave;
  logic a_rx_tick, a_rx_wave, a_tx_tick, a_tx_wave;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_baud_gen uut (
    .clk(clk), .rst(rst),
    .rx_rate(rx_rate), .rx_load(rx_load),
    .tx_rate(tx_rate), .tx_load(tx_load),
    .rx_tick(rx_tick), .rx_wave(rx_wave),
    .tx_tick(tx_tick), .tx_wave(tx_wave)
  );

  dual_baud_gen #(.TABLE_SET(1)) uut_alt (
    .clk(clk), .rst(rst),
    .rx_rate(a_rx_rate), .rx_load(a_rx_load),
    .tx_rate(4'd0), .tx_load(1'b0),
    .rx_tick(a_rx_tick), .rx_wave(a_rx_wave),
    .tx_tick(a_tx_tick), .tx_wave(a_tx_wave)
  );

  // Expected divisor: nearest integer (ties down) to ref / (16 * baud),
  // with baud held in half-units so 134.5 stays integral.
  function automatic int exp_div(input int set_sel, input int code);
    int ref_hz, half_baud, num, den, q, r;
    ref_hz = (set_sel == 1) ? 4915200 : 5068800;
    case (code)
      0: half_baud = 100;    1: half_baud = 150;    2: half_baud = 220;
      3: half_baud = 269;    4: half_baud = 300;    5: half_baud = 600;
      6: half_baud = 1200;   7: half_baud = 2400;   8: half_baud = 3600;
      9: half_baud = 4000;   10: half_baud = 4800;  11: half_baud = 7200;
      12: half_baud = 9600;  13: half_baud = 14400; 14: half_baud = 19200;
      default: half_baud = 38400;
    endcase
    num = ref_hz * 2;
    den = 16 * half_baud;
    q = num / den;
    r = num % den;
    if (2 * r > den) q = q + 1;
    return q;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic get_tick(input int which);
    case (which)
      0: return rx_tick;
      1: return tx_tick;
      default: return a_rx_tick;
    endcase
  endfunction

  function automatic logic get_wave(input int which);
    case (which)
      0: return rx_wave;
      1: return tx_wave;
      default: return a_rx_wave;
    endcase
  endfunction

  task automatic load_code(input int which, input int code);
    @(negedge clk);
    case (which)
      0: begin rx_rate = 4'(code); rx_load = 1'b1; end
      1: begin tx_rate = 4'(code); tx_load = 1'b1; end
      default: begin a_rx_rate = 4'(code); a_rx_load = 1'b1; end
    endcase
    @(negedge clk);
    rx_load = 1'b0; tx_load = 1'b0; a_rx_load = 1'b0;
  endtask

  task automatic wait_tick(input int which);
    do @(negedge clk); while (!get_tick(which));
  endtask

  // Called at a tick; counts cycles and wave-high cycles up to the next tick.
  task automatic count_period(input int which, output int n, output int h);
    n = 0; h = 0;
    do begin
      @(negedge clk);
      n++;
      if (get_wave(which)) h++;
    end while (!get_tick(which));
  endtask

  task automatic measure(input int which, output int n, output int h);
    wait_tick(which);
    count_period(which, n, h);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    check("R9", "rx_tick in reset", int'(rx_tick), 0);
    check("R9", "rx_wave in reset", int'(rx_wave), 1);
    check("R9", "tx_tick in reset", int'(tx_tick), 0);
    check("R9", "tx_wave in reset", int'(tx_wave), 1);
    rst = 1'b0;
  endtask

  task automatic t_sweep_tx;  // R1 R3 R4 R7
    int n, h, e;
    for (int c = 0; c < 16; c++) begin
      load_code(1, c);
      measure(1, n, h);
      e = exp_div(0, c);
      check("R4", $sformatf("tx period code %0d", c), n, e);
      check("R7", $sformatf("tx wave high code %0d", c), h, e - e / 2);
      if (c == 5) check("R1", "tx ticks/s at 300 baud", 5068800 / n, 4800);
    end
  endtask

  task automatic t_sweep_alt_rx;  // R2 R5 R7
    int n, h, e;
    for (int c = 0; c < 16; c++) begin
      load_code(2, c);
      measure(2, n, h);
      e = exp_div(1, c);
      check("R5", $sformatf("set1 rx period code %0d", c), n, e);
      check("R7", $sformatf("set1 rx wave high code %0d", c), h, e - e / 2);
    end
  endtask

  task automatic t_rx_load_low;  // R2
    int n, h;
    load_code(0, 14);
    measure(0, n, h);
    check("R2", "rx period after load", n, exp_div(0, 14));
    @(negedge clk);
    rx_rate = 4'd3;
    measure(0, n, h);
    check("R2", "rx period with load low", n, exp_div(0, 14));
    measure(0, n, h);
    check("R2", "rx period with load low again", n, exp_div(0, 14));
  endtask

  task automatic t_tx_level;  // R3
    int n, h;
    @(negedge clk);
    tx_rate = 4'd0;
    measure(1, n, h);
    check("R3", "tx period with load low", n, exp_div(0, 15));
    measure(1, n, h);
    check("R3", "tx period with load low again", n, exp_div(0, 15));
    @(negedge clk);
    tx_load = 1'b1;
    tx_rate = 4'd13;
    measure(1, n, h);
    check("R3", "tx follows with load tied high", n, exp_div(0, 13));
    @(negedge clk);
    tx_rate = 4'd12;
    measure(1, n, h);
    check("R3", "tx follows second code", n, exp_div(0, 12));
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic t_no_runt;  // R6
    int n, h;
    load_code(1, 5);
    measure(1, n, h);
    check("R6", "tx steady period", n, exp_div(0, 5));
    wait_tick(1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 100) begin tx_rate = 4'd15; tx_load = 1'b1; end
      if (n == 101) tx_load = 1'b0;
    end while (!tx_tick);
    check("R6", "period with midway change", n, exp_div(0, 5));
    count_period(1, n, h);
    check("R6", "period after change", n, exp_div(0, 15));
  endtask

  task automatic t_independent;  // R8
    int n, h;
    load_code(0, 15);
    load_code(1, 10);
    measure(0, n, h);
    check("R8", "rx period beside tx", n, exp_div(0, 15));
    measure(1, n, h);
    check("R8", "tx period beside rx", n, exp_div(0, 10));
    measure(0, n, h);
    check("R8", "rx period unchanged", n, exp_div(0, 15));
  endtask

  task automatic t_reset_mid;  // R9
    int n, h;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "tx_tick after mid reset", int'(tx_tick), 0);
    check("R9", "rx_wave after mid reset", int'(rx_wave), 1);
    rst = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!tx_tick);
    check("R9", "first tx tick latency", n, exp_div(0, 0) - 1);
    check("R9", "rx ticks with tx after reset", int'(rx_tick), 1);
    count_period(1, n, h);
    check("R9", "tx period after reset", n, exp_div(0, 0));
  endtask

  initial begin
    t_reset_state();
    t_sweep_tx();
    t_sweep_alt_rx();
    t_rx_load_low();
    t_tx_level();
    t_no_runt();
    t_independent();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule